// File: doc/BRIEF.md
# 17x17 Multiply-Accumulate Unit

This block multiplies two 17-bit two's-complement operands and adds the product to a 40-bit accumulator value. The whole sum is formed in one clock. Each operand starts as a 16-bit word taken from one of several sources. A mode input picks sign extension or zero extension to reach 17 bits.

The same pass can do four more things:
- double the product for fractional arithmetic,
- round the sum to the nearest upper word,
- detect overflow of the 32-bit range and optionally clamp to it,
- flag a zero result.

The block also holds a 16-bit holding register that software-visible logic elsewhere loads. It serves as one of the first-operand sources.

An instruction decoder drives the selects and mode bits for each issued operation. It also supplies the current accumulator value. It writes the registered result back into the accumulator. The result, the zero flag and the overflow flag appear on the clock edge after the operation is issued.

Top module: `mac17_unit`

## Requirements
- R1: After reset `result` is 0 and `resValid`, `zeroFlag` and `ovfFlag` are 0. The holding register is 0, so a multiply that uses it leaves the accumulator value unchanged.
- R2: `selX` picks the first operand:
  - 0 or 3: the holding register.
  - 1: `dataA`.
  - 2: `accIn[31:16]`.
- R3: `selY` picks the second operand:
  - 0: `progWord`.
  - 1: `dataB`.
  - 2: `accIn[31:16]`.
  - 3: `immWord`.
- R4: With `signedMode` = 1 both 16-bit operands are sign-extended to 17 bits. With `signedMode` = 0 they get a zero bit 16.
- R5: When `opValid` is high at a clock edge, `result` becomes (accIn + product) modulo 2^40 at that edge, with `accIn` read as signed, and `resValid` is 1 for the following cycle.
- R6: With `fracMode` = 1 the product is doubled before the addition.
- R7: With `roundEn` = 1 the value 0x8000 is added to the sum, then bits 15..0 are cleared. Rounding happens before the range check.
- R8: `ovfFlag` is 1 when the rounded sum lies outside [-2^31, 2^31-1]. If `satEn` = 1 in that case, `result` is clamped to 0x007FFFFFFF (positive) or 0xFF80000000 (negative). If `satEn` = 0, the low 40 bits are kept.
- R9: `zeroFlag` is 1 exactly when the final 40-bit result is zero.
- R10: A high `tLoad` at a clock edge loads `tIn` into the holding register. A multiply issued at that same edge uses the previous holding-register value.
- R11: When `opValid` is low at an edge, `result`, `zeroFlag` and `ovfFlag` hold and `resValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Issue a multiply-accumulate this cycle |
| tLoad | input | 1 | Load the holding register from tIn |
| tIn | input | 16 | Holding register load value |
| dataA | input | 16 | First data operand |
| dataB | input | 16 | Second data operand |
| progWord | input | 16 | Program-memory word operand |
| immWord | input | 16 | Immediate operand |
| accIn | input | 40 | Accumulator value to add, and source of the high word |
| selX | input | 2 | First operand select |
| selY | input | 2 | Second operand select |
| signedMode | input | 1 | 1 = sign-extend operands, 0 = zero-extend |
| fracMode | input | 1 | Double the product |
| roundEn | input | 1 | Round to the upper word |
| satEn | input | 1 | Clamp to the 32-bit range on overflow |
| result | output | 40 | Registered result |
| resValid | output | 1 | Result written on the last edge |
| zeroFlag | output | 1 | Result is zero |
| ovfFlag | output | 1 | Rounded sum left the 32-bit range |

## Verification
Rounding and saturation can act in the same cycle. A sum just below the positive 32-bit limit, such as 0x007FFFFFFF with a zero product, is pushed over the limit by the rounding increment alone. The bench checks that the overflow flag rises and that the clamp value, not the rounded value, is returned. A holding-register load and a multiply that reads that register are also issued at the same edge. The bench checks that the old value is used and the new value appears only on the next operation.

// File: rtl/mac17_pkg.sv
package mac17_pkg;

  // One-hot operand routing and mode strobes from control to datapath
  typedef struct packed {
    logic       capture;    // latch a new result this edge
    logic       tCapture;   // latch the holding register this edge
    logic [2:0] xPick;      // {accHigh, dataA, holdReg}
    logic [3:0] yPick;      // {imm, accHigh, dataB, prog}
    logic       signedOp;
    logic       fracOp;
    logic       roundOp;
    logic       satOp;
  } macStrobes_t;

endpackage

// File: rtl/mac17_ctrl.sv
module mac17_ctrl
  import mac17_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic        tLoad,
  input  logic [1:0]  selX,
  input  logic [1:0]  selY,
  input  logic        signedMode,
  input  logic        fracMode,
  input  logic        roundEn,
  input  logic        satEn,
  output macStrobes_t strobes
);

  always_comb begin
    strobes          = '0;
    strobes.capture  = opValid;
    strobes.tCapture = tLoad;
    strobes.signedOp = signedMode;
    strobes.fracOp   = fracMode;
    strobes.roundOp  = roundEn;
    strobes.satOp    = satEn;
    unique case (selX)
      2'd1:    strobes.xPick = 3'b010;
      2'd2:    strobes.xPick = 3'b100;
      default: strobes.xPick = 3'b001;  // codes 0 and 3 both read the holding register
    endcase
    strobes.yPick = 4'b0001 << selY;
  end

  // R2
  x_route_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(strobes.xPick));

  // R3
  y_route_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(strobes.yPick));

endmodule

// File: rtl/mac17_datapath.sv
module mac17_datapath
  import mac17_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40,
  parameter int SAT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  macStrobes_t       strobes,
  input  logic [DATA_W-1:0] tIn,
  input  logic [DATA_W-1:0] dataA,
  input  logic [DATA_W-1:0] dataB,
  input  logic [DATA_W-1:0] progWord,
  input  logic [DATA_W-1:0] immWord,
  input  logic [ACC_W-1:0]  accIn,
  output logic [ACC_W-1:0]  result,
  output logic              resValid,
  output logic              zeroFlag,
  output logic              ovfFlag
);

  localparam int OP_W   = DATA_W + 1;
  localparam int PROD_W = 2 * OP_W;
  localparam int WIDE_W = ACC_W + 2;
  localparam int EXT_W  = WIDE_W - PROD_W - 1;
  localparam logic [WIDE_W-1:0] ROUND_ADD = WIDE_W'(1) << (DATA_W - 1);
  localparam logic [ACC_W-1:0]  SAT_MAX = {{(ACC_W-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic [ACC_W-1:0]  SAT_MIN = {{(ACC_W-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] accHigh, xRaw, yRaw;
  logic signed [OP_W-1:0]   xOp, yOp;
  logic signed [PROD_W-1:0] prodFull;
  logic [PROD_W:0]          prodScaled;
  logic [WIDE_W-1:0]        accWide, prodWide, sumWide, roundSum, roundWide;
  logic                     posOvf, negOvf, rangeOvf;
  logic [ACC_W-1:0]         nextRes;
  logic                     lastSat, lastRound;

  // Holding register
  always_ff @(posedge clk) begin
    if (!rstN)                 holdReg <= '0;
    else if (strobes.tCapture) holdReg <= tIn;
  end

  // Operand routing (AND-OR of one-hot picks)
  assign accHigh = accIn[2*DATA_W-1:DATA_W];
  assign xRaw = ({DATA_W{strobes.xPick[0]}} & holdReg)
              | ({DATA_W{strobes.xPick[1]}} & dataA)
              | ({DATA_W{strobes.xPick[2]}} & accHigh);
  assign yRaw = ({DATA_W{strobes.yPick[0]}} & progWord)
              | ({DATA_W{strobes.yPick[1]}} & dataB)
              | ({DATA_W{strobes.yPick[2]}} & accHigh)
              | ({DATA_W{strobes.yPick[3]}} & immWord);

  // Extension to 17 bits and multiply
  assign xOp      = {strobes.signedOp & xRaw[DATA_W-1], xRaw};
  assign yOp      = {strobes.signedOp & yRaw[DATA_W-1], yRaw};
  assign prodFull = xOp * yOp;

  // Fractional doubling
  assign prodScaled = strobes.fracOp ? {prodFull, 1'b0}
                                     : {prodFull[PROD_W-1], prodFull};

  // Wide addition, so overflow remains visible
  assign accWide  = {{2{accIn[ACC_W-1]}}, accIn};
  assign prodWide = {{EXT_W{prodScaled[PROD_W]}}, prodScaled};
  assign sumWide  = accWide + prodWide;

  // Round to nearest upper word
  assign roundSum  = sumWide + ROUND_ADD;
  assign roundWide = strobes.roundOp ? {roundSum[WIDE_W-1:DATA_W], {DATA_W{1'b0}}}
                                     : sumWide;

  // Range check against the signed 32-bit window
  assign posOvf   = !roundWide[WIDE_W-1] && (|roundWide[WIDE_W-2:SAT_W-1]);
  assign negOvf   =  roundWide[WIDE_W-1] && !(&roundWide[WIDE_W-2:SAT_W-1]);
  assign rangeOvf = posOvf || negOvf;

  always_comb begin
    nextRes = roundWide[ACC_W-1:0];
    if (strobes.satOp && posOvf) nextRes = SAT_MAX;
    if (strobes.satOp && negOvf) nextRes = SAT_MIN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result    <= '0;
      resValid  <= 1'b0;
      zeroFlag  <= 1'b0;
      ovfFlag   <= 1'b0;
      lastSat   <= 1'b0;
      lastRound <= 1'b0;
    end else begin
      resValid <= strobes.capture;
      if (strobes.capture) begin
        result    <= nextRes;
        zeroFlag  <= (nextRes == '0);
        ovfFlag   <= rangeOvf;
        lastSat   <= strobes.satOp;
        lastRound <= strobes.roundOp;
      end
    end
  end

  // R8
  sat_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && lastSat) |-> (result[ACC_W-1:SAT_W-1] == '0 || (&result[ACC_W-1:SAT_W-1])));

  // R8
  sat_clamp_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && lastSat && ovfFlag) |-> (result == SAT_MAX || result == SAT_MIN));

  // R7
  round_low_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && lastRound && !ovfFlag) |-> (result[DATA_W-1:0] == '0));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(result) && $stable(zeroFlag) && $stable(ovfFlag) && !resValid));

  // R10
  hold_reg_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.tCapture |=> $stable(holdReg));

endmodule

// File: rtl/mac17_unit.sv
module mac17_unit
  import mac17_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic        tLoad,
  input  logic [15:0] tIn,
  input  logic [15:0] dataA,
  input  logic [15:0] dataB,
  input  logic [15:0] progWord,
  input  logic [15:0] immWord,
  input  logic [39:0] accIn,
  input  logic [1:0]  selX,
  input  logic [1:0]  selY,
  input  logic        signedMode,
  input  logic        fracMode,
  input  logic        roundEn,
  input  logic        satEn,
  output logic [39:0] result,
  output logic        resValid,
  output logic        zeroFlag,
  output logic        ovfFlag
);

  macStrobes_t strobes;

  mac17_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .opValid    (opValid),
    .tLoad      (tLoad),
    .selX       (selX),
    .selY       (selY),
    .signedMode (signedMode),
    .fracMode   (fracMode),
    .roundEn    (roundEn),
    .satEn      (satEn),
    .strobes    (strobes)
  );

  mac17_datapath #(.DATA_W(16), .ACC_W(40), .SAT_W(32)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .tIn      (tIn),
    .dataA    (dataA),
    .dataB    (dataB),
    .progWord (progWord),
    .immWord  (immWord),
    .accIn    (accIn),
    .result   (result),
    .resValid (resValid),
    .zeroFlag (zeroFlag),
    .ovfFlag  (ovfFlag)
  );

endmodule

// File: tb/tb_mac17_unit.sv
`timescale 1ns/1ps
module tb_mac17_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0, tLoad = 1'b0;
  logic [15:0] tIn = '0, dataA = '0, dataB = '0, progWord = '0, immWord = '0;
  logic [39:0] accIn = '0;
  logic [1:0]  selX = '0, selY = '0;
  logic        signedMode = 1'b0, fracMode = 1'b0, roundEn = 1'b0, satEn = 1'b0;
  logic [39:0] result;
  logic        resValid, zeroFlag, ovfFlag;

  int errors = 0;
  int checks = 0;
  logic [15:0] tModel = '0;

  always #10 clk = ~clk;

  mac17_unit dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic longint extend(input logic [15:0] v, input bit sgn);
    if (sgn) return longint'($signed(v));
    return longint'({48'd0, v});
  endfunction

  // Expected value computed from the requirements
  task automatic model(input logic [15:0] xv, input logic [15:0] yv, input logic [39:0] acc,
                       input bit sgn, input bit frac, input bit rnd, input bit sat,
                       output logic [39:0] r, output bit z, output bit o);
    longint s;
    s = longint'($signed(acc)) + extend(xv, sgn) * extend(yv, sgn) * (frac ? 2 : 1);
    if (rnd) s = (s + 32768) & ~longint'(65535);
    o = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    if (sat && o) r = (s > 0) ? 40'h007FFFFFFF : 40'hFF80000000;
    else          r = s[39:0];
    z = (r == 40'd0);
  endtask

  // Issue one operation at a falling edge, then read the outputs at the next falling edge
  task automatic runOp(input string req, input logic [1:0] sx, input logic [1:0] sy,
                       input logic [15:0] a, input logic [15:0] b, input logic [15:0] p,
                       input logic [15:0] im, input logic [39:0] acc,
                       input bit sgn, input bit frac, input bit rnd, input bit sat);
    logic [15:0] xv, yv;
    logic [39:0] er;
    bit ez, eo;
    case (sx)
      2'd1: xv = a;
      2'd2: xv = acc[31:16];
      default: xv = tModel;
    endcase
    case (sy)
      2'd0: yv = p;
      2'd1: yv = b;
      2'd2: yv = acc[31:16];
      default: yv = im;
    endcase
    model(xv, yv, acc, sgn, frac, rnd, sat, er, ez, eo);
    @(negedge clk);
    opValid = 1'b1; selX = sx; selY = sy; dataA = a; dataB = b; progWord = p; immWord = im;
    accIn = acc; signedMode = sgn; fracMode = frac; roundEn = rnd; satEn = sat;
    @(negedge clk);
    opValid = 1'b0;
    check({req, " result"}, 64'(result), 64'(er));
    check({req, " zeroFlag"}, 64'(zeroFlag), 64'(ez));
    check({req, " ovfFlag"}, 64'(ovfFlag), 64'(eo));
    check({req, " resValid"}, 64'(resValid), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  localparam logic [15:0] VALS [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
                                       16'h8000, 16'h1234, 16'hC001, 16'h0100};
  localparam logic [39:0] ACCS [3] = '{40'h0000000000, 40'h0000012345, 40'hFFFF800000};

  initial begin
    logic [39:0] keep;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 result", 64'(result), 64'd0);
    check("R1 resValid", 64'(resValid), 64'd0);
    check("R1 zeroFlag", 64'(zeroFlag), 64'd0);
    check("R1 ovfFlag", 64'(ovfFlag), 64'd0);
    rstN = 1'b1;
    // R1 holding register cleared: product is zero
    runOp("R1", 2'd0, 2'd3, 16'h5, 16'h5, 16'h5, 16'h7777, 40'h0000001234, 1, 0, 0, 0);

    // R4 R5 R6 sweep over operands, extension and doubling
    foreach (ACCS[k])
      for (int s = 0; s < 2; s++)
        for (int f = 0; f < 2; f++)
          foreach (VALS[i])
            foreach (VALS[j])
              runOp("R4 R5 R6 sweep", 2'd1, 2'd1, VALS[i], VALS[j], 16'h0, 16'h0,
                    ACCS[k], bit'(s), bit'(f), 0, 0);

    // R2 and R3 operand selection codes
    runOp("R2 x=dataA", 2'd1, 2'd0, 16'd3, 16'd9, 16'd7, 16'd11, 40'h0005550000, 0, 0, 0, 0);
    runOp("R2 x=accHigh", 2'd2, 2'd0, 16'd3, 16'd9, 16'd7, 16'd11, 40'h0000050000, 0, 0, 0, 0);
    runOp("R3 y=dataB", 2'd1, 2'd1, 16'd3, 16'd9, 16'd7, 16'd11, 40'd0, 0, 0, 0, 0);
    runOp("R3 y=accHigh", 2'd1, 2'd2, 16'd3, 16'd9, 16'd7, 16'd11, 40'h0000060000, 0, 0, 0, 0);
    runOp("R3 y=imm", 2'd1, 2'd3, 16'd3, 16'd9, 16'd7, 16'd11, 40'd0, 0, 0, 0, 0);

    // R10 load and read in the same cycle uses the old value
    @(negedge clk);
    tLoad = 1'b1; tIn = 16'h0042;
    opValid = 1'b1; selX = 2'd0; selY = 2'd3; immWord = 16'd2; accIn = 40'd0;
    signedMode = 1; fracMode = 0; roundEn = 0; satEn = 0;
    @(negedge clk);
    tLoad = 1'b0; opValid = 1'b0;
    check("R10 same-cycle old value", 64'(result), 64'd0);
    tModel = 16'h0042;
    runOp("R10 new value", 2'd0, 2'd3, 16'd0, 16'd0, 16'd0, 16'd2, 40'd0, 1, 0, 0, 0);
    runOp("R2 x code 3", 2'd3, 2'd3, 16'd0, 16'd0, 16'd0, 16'd3, 40'd1, 1, 0, 0, 0);

    // R7 rounding
    runOp("R7 round up", 2'd1, 2'd1, 16'd0, 16'd0, 16'd0, 16'd0, 40'h0000128000, 1, 0, 1, 0);
    runOp("R7 round down", 2'd1, 2'd1, 16'd0, 16'd0, 16'd0, 16'd0, 40'h0000127FFF, 1, 0, 1, 0);
    runOp("R7 round negative", 2'd1, 2'd1, 16'h8000, 16'h0003, 16'd0, 16'd0, 40'h0000000000, 1, 1, 1, 0);

    // R8 overflow and saturation
    runOp("R8 pos clamp", 2'd1, 2'd1, 16'h7FFF, 16'h7FFF, 16'd0, 16'd0, 40'h007FFF0000, 1, 1, 0, 1);
    runOp("R8 neg clamp", 2'd1, 2'd1, 16'h8000, 16'h7FFF, 16'd0, 16'd0, 40'hFF80010000, 1, 1, 0, 1);
    runOp("R8 no sat wrap", 2'd1, 2'd1, 16'h7FFF, 16'h7FFF, 16'd0, 16'd0, 40'h007FFF0000, 1, 1, 0, 0);
    runOp("R8 in range", 2'd1, 2'd1, 16'd1, 16'd1, 16'd0, 16'd0, 40'h007FFFFFFE, 1, 0, 0, 1);
    runOp("R7 R8 round pushes over", 2'd1, 2'd1, 16'd0, 16'd0, 16'd0, 16'd0, 40'h007FFFFFFF, 1, 0, 1, 1);
    runOp("R7 R8 round at negative edge", 2'd1, 2'd1, 16'd0, 16'd0, 16'd0, 16'd0, 40'hFF80000000, 1, 0, 1, 1);

    // R9 zero detection
    runOp("R9 cancel", 2'd1, 2'd1, 16'd2, 16'd3, 16'd0, 16'd0, 40'hFFFFFFFFFA, 1, 0, 0, 0);
    runOp("R9 round to zero", 2'd1, 2'd1, 16'd0, 16'd0, 16'd0, 16'd0, 40'h0000007FFF, 1, 0, 1, 0);
    runOp("R9 nonzero", 2'd1, 2'd1, 16'd2, 16'd3, 16'd0, 16'd0, 40'd0, 1, 0, 0, 0);

    // R11 idle cycle holds outputs
    keep = result;
    @(negedge clk);
    opValid = 1'b0; dataA = 16'h7FFF; dataB = 16'h7FFF; accIn = 40'h0012345678; selX = 2'd1; selY = 2'd1;
    @(negedge clk);
    check("R11 result held", 64'(result), 64'(keep));
    check("R11 resValid low", 64'(resValid), 64'd0);
    check("R11 zeroFlag held", 64'(zeroFlag), 64'd0);
    check("R11 ovfFlag held", 64'(ovfFlag), 64'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule